// File: doc/BRIEF.md
# DMA Descriptor Submission Register Interface

This block is the register front end of a single-channel DMA engine. Software stages a transfer in a set of registers: source and destination address, X and Y length, two strides and a flags word. A write to the start register then pushes the staged transfer into a small hardware queue. On acceptance the block tags the transfer with a 2-bit transfer ID, which software can read from the ID register before it issues the start.

The datapath pulls queued descriptors over a valid/ready handshake, in the order they were queued. When it finishes a transfer it returns that transfer's ID on a completion strobe. The block sets the matching bit in a done bitmask and raises an end-of-transfer interrupt. Each handoff frees a queue slot and raises a start-of-transfer interrupt.

The control register can pause handoffs or disable the channel. Disabling also discards all queued and in-flight work.

Top module: `dmadesc_regif`

## Requirements
- R1: After reset the mask register (0x080) reads 3 (all sources masked), the pending register (0x084), control (0x400), next-ID (0x404) and start/full (0x408) registers read 0, and `irq` is 0.
- R2: Writing 1 to bit 0 of 0x408 while the channel is enabled queues the staged fields. The staged fields are flags bit 0 (cyclic) at 0x40C, destination address at 0x410, source address at 0x414, X length at 0x418, Y length at 0x41C, destination stride at 0x420 and source stride at 0x424. Queued descriptors appear on `desc_*` with `desc_valid` and leave on `desc_valid && desc_ready`, strictly in queue order.
- R3: Register 0x404 shows the ID the next accepted start will receive. It advances by one, modulo 4, on each accepted start.
- R4: A transfer is outstanding from its accepted start until its non-cyclic completion. Reading 0x408 returns 1 when 4 transfers are outstanding and 0 otherwise. A start while 4 are outstanding, or while the channel is disabled, is ignored.
- R5: Each handoff sets pending bit 0 (start-of-transfer). Each completion sets pending bit 1 (end-of-transfer). Writing 1 to a pending bit clears it. The source register (0x088) reads pending AND NOT mask, and `irq` is the OR of those bits. Writing 0 to the mask unmasks everything.
- R6: A completion with `done_id` = N sets bit N of the done register (0x428). Reading 0x428 clears all of its bits.
- R7: When an ID is assigned to a newly queued descriptor, its done bit is cleared.
- R8: Control bit 0 enables the channel and bit 1 pauses it. While paused, `desc_valid` stays low. A control write with bit 0 at 0 discards every queued and outstanding transfer.
- R9: A completion of a transfer queued with the cyclic flag sets its done bit and the end-of-transfer bit, but the transfer stays outstanding.
- R10: Register 0x42C reads the ID of the descriptor most recently handed to the datapath.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears one cycle later |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| desc_valid | output | 1 | Head descriptor available to datapath |
| desc_ready | input | 1 | Datapath accepts the head descriptor |
| desc_src | output | 32 | Source address |
| desc_dst | output | 32 | Destination address |
| desc_xlen | output | 24 | X length as written |
| desc_ylen | output | 24 | Y length as written |
| desc_sstride | output | 24 | Source stride |
| desc_dstride | output | 24 | Destination stride |
| desc_cyclic | output | 1 | Cyclic flag |
| desc_id | output | 2 | Transfer ID |
| done_valid | input | 1 | Datapath completion strobe |
| done_id | input | 2 | ID of the completed transfer |
| irq | output | 1 | Interrupt request |

## Verification
A wrong outstanding count shows on the start register at the next read: it reports full too early or too late, and a start that should be refused instead bumps the next-ID register. Queue pointer or ID corruption shows on the very next handoff as a descriptor with the wrong fields or the wrong ID, caught by the in-order scoreboard. A stuck pending or done bit shows one read later as a nonzero value after a write-one-to-clear or a clear-on-read. It also shows as `irq` staying high in the cycle after the clear.

// File: rtl/dmadesc_pkg.sv
package dmadesc_pkg;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 24;
  localparam int ID_W   = 2;
  localparam int NUM_ID = 1 << ID_W;

  typedef struct packed {
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
    logic [LEN_W-1:0]  xlen;
    logic [LEN_W-1:0]  ylen;
    logic [LEN_W-1:0]  sstride;
    logic [LEN_W-1:0]  dstride;
    logic              cyclic;
    logic [ID_W-1:0]   id;
  } desc_t;

  localparam logic [11:0] RA_MASK   = 12'h080;
  localparam logic [11:0] RA_PEND   = 12'h084;
  localparam logic [11:0] RA_SRC    = 12'h088;
  localparam logic [11:0] RA_CTRL   = 12'h400;
  localparam logic [11:0] RA_NEXTID = 12'h404;
  localparam logic [11:0] RA_START  = 12'h408;
  localparam logic [11:0] RA_FLAGS  = 12'h40C;
  localparam logic [11:0] RA_DADDR  = 12'h410;
  localparam logic [11:0] RA_SADDR  = 12'h414;
  localparam logic [11:0] RA_XLEN   = 12'h418;
  localparam logic [11:0] RA_YLEN   = 12'h41C;
  localparam logic [11:0] RA_DSTR   = 12'h420;
  localparam logic [11:0] RA_SSTR   = 12'h424;
  localparam logic [11:0] RA_DONE   = 12'h428;
  localparam logic [11:0] RA_ACTID  = 12'h42C;
endpackage

// File: rtl/desc_fifo.sv
module desc_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         flush,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic [PW:0]  count
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      count <= count + (PW+1)'(push) - (PW+1)'(pop);
    end
  end

  assign dout = mem[rptr];

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    (push && !flush) |-> (count < (PW+1)'(DEPTH)))
    else $error("queue push while full");
  p_no_underflow_r2: assert property (@(posedge clk) disable iff (rst)
    (pop && !flush) |-> (count != '0))
    else $error("queue pop while empty");
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic         w1c_en,
  input  logic [N-1:0] w1c,
  input  logic         mask_wr,
  input  logic [N-1:0] mask_wdata,
  output logic [N-1:0] mask,
  output logic [N-1:0] pend,
  output logic         irq
);
  logic [N-1:0] pend_d, mask_d;

  always_comb begin
    pend_d = (pend & ~(w1c_en ? w1c : '0)) | set;
    mask_d = mask_wr ? mask_wdata : mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= '0;
      mask <= '1;
      irq  <= 1'b0;
    end else begin
      pend <= pend_d;
      mask <= mask_d;
      irq  <= |(pend_d & ~mask_d);
    end
  end

  p_w1c_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (w1c_en && w1c[0] && !set[0]) |=> !pend[0])
    else $error("pending bit survived write-one-to-clear");
  p_set_sticks_r5: assert property (@(posedge clk) disable iff (rst)
    set[1] |=> pend[1])
    else $error("completion did not set pending");
endmodule

// File: rtl/done_tracker.sv
module done_tracker #(
  parameter int ID_W = 2,
  localparam int NID = 1 << ID_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic            assign_en,
  input  logic [ID_W-1:0] assign_id,
  input  logic            assign_cyc,
  input  logic            cpl_en,
  input  logic [ID_W-1:0] cpl_id,
  input  logic            rd_clr,
  output logic [NID-1:0]  done_bits,
  output logic            slots_full
);
  logic [NID-1:0] cyc_q;
  logic [ID_W:0]  outstanding;
  logic [NID-1:0] clr_mask, set_mask;
  logic           retire;

  always_comb begin
    clr_mask = (rd_clr ? '1 : '0) | (assign_en ? (NID'(1) << assign_id) : '0);
    set_mask = cpl_en ? (NID'(1) << cpl_id) : '0;
    retire   = cpl_en && !cyc_q[cpl_id];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_bits <= '0;
    end else begin
      done_bits <= (done_bits & ~clr_mask) | set_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      cyc_q       <= '0;
      outstanding <= '0;
    end else begin
      if (assign_en) cyc_q[assign_id] <= assign_cyc;
      outstanding <= outstanding + (ID_W+1)'(assign_en) - (ID_W+1)'(retire);
    end
  end

  assign slots_full = (outstanding == (ID_W+1)'(NID));

  p_outstanding_bound_r4: assert property (@(posedge clk) disable iff (rst)
    outstanding <= (ID_W+1)'(NID))
    else $error("outstanding count beyond ID space");
  p_done_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && !cpl_en) |=> (done_bits == '0))
    else $error("done bits survived read");
  p_reassign_r7: assert property (@(posedge clk) disable iff (rst)
    (assign_en && !cpl_en) |=> !done_bits[$past(assign_id)])
    else $error("done bit not cleared on reassignment");
endmodule

// File: rtl/dmadesc_regif.sv
module dmadesc_regif
  import dmadesc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              desc_valid,
  input  logic              desc_ready,
  output logic [ADDR_W-1:0] desc_src,
  output logic [ADDR_W-1:0] desc_dst,
  output logic [LEN_W-1:0]  desc_xlen,
  output logic [LEN_W-1:0]  desc_ylen,
  output logic [LEN_W-1:0]  desc_sstride,
  output logic [LEN_W-1:0]  desc_dstride,
  output logic              desc_cyclic,
  output logic [ID_W-1:0]   desc_id,
  input  logic              done_valid,
  input  logic [ID_W-1:0]   done_id,
  output logic              irq
);
  localparam int DW = $bits(desc_t);
  localparam int CW = ID_W + 1;

  logic              ctrl_en, ctrl_pause;
  logic              stg_cyc;
  logic [ADDR_W-1:0] stg_src, stg_dst;
  logic [LEN_W-1:0]  stg_xlen, stg_ylen, stg_sstr, stg_dstr;
  logic [ID_W-1:0]   next_id, active_id;
  logic [CW-1:0]     q_count;
  logic [NUM_ID-1:0] done_bits;
  logic [1:0]        irq_mask, irq_pend;
  logic              slots_full, flush, start_acc, handoff, cpl_en, rd_done;
  desc_t             stg_desc, head;
  logic [DW-1:0]     head_bits;

  function automatic logic wr_at(input logic [11:0] off);
    return reg_wr && (reg_addr == off);
  endfunction

  assign flush     = wr_at(RA_CTRL) && !reg_wdata[0];
  assign start_acc = wr_at(RA_START) && reg_wdata[0] && ctrl_en && !slots_full;
  assign cpl_en    = done_valid && ctrl_en;
  assign rd_done   = reg_rd && (reg_addr == RA_DONE);

  always_comb begin
    stg_desc = '{src: stg_src, dst: stg_dst, xlen: stg_xlen, ylen: stg_ylen,
                 sstride: stg_sstr, dstride: stg_dstr, cyclic: stg_cyc, id: next_id};
  end

  desc_fifo #(.W(DW), .DEPTH(NUM_ID)) u_queue (
    .clk(clk), .rst(rst), .flush(flush), .push(start_acc), .din(stg_desc),
    .pop(handoff), .dout(head_bits), .count(q_count)
  );

  assign head       = desc_t'(head_bits);
  assign desc_valid = (q_count != '0) && ctrl_en && !ctrl_pause;
  assign handoff    = desc_valid && desc_ready;
  assign desc_src     = head.src;
  assign desc_dst     = head.dst;
  assign desc_xlen    = head.xlen;
  assign desc_ylen    = head.ylen;
  assign desc_sstride = head.sstride;
  assign desc_dstride = head.dstride;
  assign desc_cyclic  = head.cyclic;
  assign desc_id      = head.id;

  done_tracker #(.ID_W(ID_W)) u_done (
    .clk(clk), .rst(rst), .flush(flush),
    .assign_en(start_acc), .assign_id(next_id), .assign_cyc(stg_cyc),
    .cpl_en(cpl_en), .cpl_id(done_id), .rd_clr(rd_done),
    .done_bits(done_bits), .slots_full(slots_full)
  );

  irq_ctrl #(.N(2)) u_irq (
    .clk(clk), .rst(rst), .set({cpl_en, handoff}),
    .w1c_en(wr_at(RA_PEND)), .w1c(reg_wdata[1:0]),
    .mask_wr(wr_at(RA_MASK)), .mask_wdata(reg_wdata[1:0]),
    .mask(irq_mask), .pend(irq_pend), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en    <= 1'b0;
      ctrl_pause <= 1'b0;
      stg_cyc    <= 1'b0;
      stg_src    <= '0;
      stg_dst    <= '0;
      stg_xlen   <= '0;
      stg_ylen   <= '0;
      stg_sstr   <= '0;
      stg_dstr   <= '0;
      next_id    <= '0;
      active_id  <= '0;
    end else begin
      if (wr_at(RA_CTRL)) begin
        ctrl_en    <= reg_wdata[0];
        ctrl_pause <= reg_wdata[1];
      end
      if (wr_at(RA_FLAGS)) stg_cyc  <= reg_wdata[0];
      if (wr_at(RA_SADDR)) stg_src  <= reg_wdata[ADDR_W-1:0];
      if (wr_at(RA_DADDR)) stg_dst  <= reg_wdata[ADDR_W-1:0];
      if (wr_at(RA_XLEN))  stg_xlen <= reg_wdata[LEN_W-1:0];
      if (wr_at(RA_YLEN))  stg_ylen <= reg_wdata[LEN_W-1:0];
      if (wr_at(RA_SSTR))  stg_sstr <= reg_wdata[LEN_W-1:0];
      if (wr_at(RA_DSTR))  stg_dstr <= reg_wdata[LEN_W-1:0];
      if (start_acc) next_id   <= next_id + 1'b1;
      if (handoff)   active_id <= head.id;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        RA_MASK:   reg_rdata <= 32'(irq_mask);
        RA_PEND:   reg_rdata <= 32'(irq_pend);
        RA_SRC:    reg_rdata <= 32'(irq_pend & ~irq_mask);
        RA_CTRL:   reg_rdata <= 32'({ctrl_pause, ctrl_en});
        RA_NEXTID: reg_rdata <= 32'(next_id);
        RA_START:  reg_rdata <= 32'(slots_full);
        RA_FLAGS:  reg_rdata <= 32'(stg_cyc);
        RA_DADDR:  reg_rdata <= 32'(stg_dst);
        RA_SADDR:  reg_rdata <= 32'(stg_src);
        RA_XLEN:   reg_rdata <= 32'(stg_xlen);
        RA_YLEN:   reg_rdata <= 32'(stg_ylen);
        RA_DSTR:   reg_rdata <= 32'(stg_dstr);
        RA_SSTR:   reg_rdata <= 32'(stg_sstr);
        RA_DONE:   reg_rdata <= 32'(done_bits);
        RA_ACTID:  reg_rdata <= 32'(active_id);
        default:   reg_rdata <= '0;
      endcase
    end
  end

  p_id_step_r3: assert property (@(posedge clk) disable iff (rst)
    start_acc |=> (next_id == $past(next_id) + 1'b1))
    else $error("ID did not advance on accepted start");
  p_desc_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (desc_valid && !desc_ready && !wr_at(RA_CTRL)) |=> (desc_valid && $stable(desc_id)))
    else $error("offered descriptor withdrawn");
  p_no_handoff_disabled_r8: assert property (@(posedge clk) disable iff (rst)
    flush |=> !desc_valid)
    else $error("descriptor offered after disable");
endmodule

// File: tb/dmadesc_regif_test.sv
module dmadesc_regif_test;
  import dmadesc_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic desc_valid, desc_ready = 1'b0;
  logic [ADDR_W-1:0] desc_src, desc_dst;
  logic [LEN_W-1:0] desc_xlen, desc_ylen, desc_sstride, desc_dstride;
  logic desc_cyclic;
  logic [ID_W-1:0] desc_id;
  logic done_valid = 1'b0;
  logic [ID_W-1:0] done_id = '0;
  logic irq;

  int total = 0, bad = 0;
  int exp_id = 0;
  desc_t sb[$];

  always #5 clk = ~clk;

  dmadesc_regif uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  // driver: stage a descriptor, start it, and push the expectation if it should be taken
  task automatic submit(input int k, input logic cyc, input bit expect_ok);
    desc_t e;
    e.src = 32'h1000_0000 + 32'(k * 64);
    e.dst = 32'h2000_0000 + 32'(k * 128);
    e.xlen = 24'(16 * k + 15); e.ylen = 24'(k);
    e.sstride = 24'(k + 3); e.dstride = 24'(k + 5);
    e.cyclic = cyc; e.id = ID_W'(exp_id);
    wr(RA_SADDR, e.src); wr(RA_DADDR, e.dst);
    wr(RA_XLEN, 32'(e.xlen)); wr(RA_YLEN, 32'(e.ylen));
    wr(RA_SSTR, 32'(e.sstride)); wr(RA_DSTR, 32'(e.dstride));
    wr(RA_FLAGS, 32'(cyc));
    wr(RA_START, 32'd1);
    if (expect_ok) begin
      sb.push_back(e);
      exp_id = (exp_id + 1) % NUM_ID;
    end
  endtask

  task automatic complete(input int id);
    @(negedge clk);
    done_valid = 1'b1; done_id = ID_W'(id);
    @(negedge clk);
    done_valid = 1'b0;
  endtask

  // monitor: compare every handoff with the head of the scoreboard (R2)
  always @(posedge clk) begin
    if (!rst && desc_valid && desc_ready) begin
      desc_t act, e;
      act = '{src: desc_src, dst: desc_dst, xlen: desc_xlen, ylen: desc_ylen,
              sstride: desc_sstride, dstride: desc_dstride, cyclic: desc_cyclic, id: desc_id};
      total++;
      if (sb.size() == 0) begin
        bad++;
        $display("FAIL R2: unexpected handoff id=%0d expected=none", desc_id);
      end else begin
        e = sb.pop_front();
        if (act !== e) begin
          bad++;
          $display("FAIL R2: actual=%0h expected=%0h", act, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    rd_chk("R1 mask", RA_MASK, 3);
    rd_chk("R1 pend", RA_PEND, 0);
    rd_chk("R1 ctrl", RA_CTRL, 0);
    rd_chk("R1 nextid", RA_NEXTID, 0);
    rd_chk("R1 start", RA_START, 0);

    wr(RA_CTRL, 1);
    wr(RA_MASK, 0);
    submit(1, 1'b0, 1'b1);
    rd_chk("R3 nextid after one", RA_NEXTID, 1);
    submit(2, 1'b0, 1'b1);
    submit(3, 1'b0, 1'b1);
    rd_chk("R4 not full at 3", RA_START, 0);
    submit(4, 1'b0, 1'b1);
    rd_chk("R4 full at 4", RA_START, 1);
    submit(5, 1'b0, 1'b0);
    rd_chk("R4 start ignored when full", RA_NEXTID, 0);

    @(negedge clk) desc_ready = 1'b1;
    repeat (6) @(negedge clk);
    check("R2 all handed out", 32'(sb.size()), 0);
    check("R5 irq after handoff", 32'(irq), 1);
    rd_chk("R5 source sot", RA_SRC, 1);
    rd_chk("R10 active id", RA_ACTID, 3);
    rd_chk("R4 still full in flight", RA_START, 1);
    wr(RA_PEND, 1);
    check("R5 irq after w1c", 32'(irq), 0);
    rd_chk("R5 pend after w1c", RA_PEND, 0);

    complete(2);
    rd_chk("R5 pend eot", RA_PEND, 2);
    rd_chk("R6 done bit", RA_DONE, 32'h4);
    rd_chk("R6 clear on read", RA_DONE, 0);
    rd_chk("R4 slot freed", RA_START, 0);

    wr(RA_PEND, 3);
    wr(RA_MASK, 2);
    complete(0);
    check("R5 masked irq", 32'(irq), 0);
    rd_chk("R5 masked source", RA_SRC, 0);
    rd_chk("R5 masked pend", RA_PEND, 2);
    wr(RA_MASK, 0);
    check("R5 unmasked irq", 32'(irq), 1);
    wr(RA_PEND, 3);

    // R8 disable flushes; start while disabled ignored
    wr(RA_CTRL, 0);
    rd_chk("R8 flush frees slots", RA_START, 0);
    submit(6, 1'b0, 1'b0);
    rd_chk("R4 start ignored disabled", RA_NEXTID, 0);
    check("R8 no offer disabled", 32'(desc_valid), 0);

    // R8 pause holds handoff
    wr(RA_CTRL, 3);
    submit(7, 1'b0, 1'b1);
    repeat (5) @(negedge clk);
    check("R8 paused no valid", 32'(desc_valid), 0);
    check("R8 paused not taken", 32'(sb.size()), 1);
    wr(RA_CTRL, 1);
    repeat (3) @(negedge clk);
    check("R8 unpause hands out", 32'(sb.size()), 0);
    rd_chk("R7 done cleared on reassign", RA_DONE, 0);
    rd_chk("R10 active id after pause", RA_ACTID, 0);
    complete(0);
    rd_chk("R6 done id0", RA_DONE, 1);

    // R9 cyclic stays outstanding
    submit(8, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    complete(1);
    complete(1);
    rd_chk("R9 cyclic done bit", RA_DONE, 2);
    @(negedge clk) desc_ready = 1'b0;
    submit(9, 1'b0, 1'b1);
    submit(10, 1'b0, 1'b1);
    submit(11, 1'b0, 1'b1);
    rd_chk("R9 cyclic keeps slot", RA_START, 1);
    @(negedge clk) desc_ready = 1'b1;
    repeat (6) @(negedge clk);
    check("R2 final drain", 32'(sb.size()), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule